// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32K bytes. The host hands it one read or write at a time over a valid/ready handshake. The controller then produces the three active-low strobes (chip select, output enable, write strobe), holds the address steady and drives or samples the shared 8-bit data bus. Read data comes back in a register, flagged by a one-cycle valid pulse.

The memory's access time and the clock period are parameters given in picoseconds. The controller works out from them how many cycles a read must wait before it samples the bus. The length of the write pulse is set in cycles.

A write is the overlap of chip select low and write strobe low, and it ends on the first of the two to rise. The controller always ends a write with the write strobe and keeps its data on the bus for one cycle after that edge. It raises output enable before it drives the bus, and it separates a read from the next access by a quiet cycle.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, chip select, output enable and write strobe are all high, the data driver is off and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the operation has fully finished, and a request held on `req_valid` during that time starts no access.
- R3: A write holds chip select low for one cycle with the write strobe high. It then holds the write strobe low for `WR_PULSE_CYC` cycles. Output enable stays high throughout the write.
- R4: The write strobe rises while chip select is still low and the data driver is still on. One hold cycle follows. Chip select then rises, the driver is released and the controller is idle again `WR_PULSE_CYC`+3 cycles after the request was taken.
- R5: A read holds chip select and output enable low with the write strobe high for exactly ceil(`ACCESS_PS`/`CLK_PS`) cycles. The address is unchanged for the whole time chip select is low. The bus is sampled on the last of those edges.
- R6: `rsp_valid` is high for exactly one cycle per read. It comes ceil(`ACCESS_PS`/`CLK_PS`)+1 cycles after the request was taken, with the sampled word on `rsp_rdata`.
- R7: After every read there is one cycle with all three strobes high and `req_ready` low before the controller becomes idle.
- R8: The data driver is never on while output enable is low, and output enable and the write strobe are never low together.
- R9: A word written at an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The assertions assume that the host never changes `req_write`, `req_addr` or `req_wdata` while a request is waiting to be taken. They also assume that the memory drives the bus only while chip select and output enable are low and the write strobe is high, so any contention can only come from the controller's own driver.

The bench drives requests only when it has seen `req_ready` high, and it lowers `req_valid` right after the accepting edge. The one exception is the busy test, which holds a second request on purpose. The bench's memory model follows the same bus rule. Until 54 ns after the read condition and address settle, it returns the inverted word, so a sample taken one cycle early shows up as wrong data.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types for the asynchronous SRAM controller.
// Assumes: one access in flight at a time; strobe levels are a pure
// function of the sequencer state.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_RTURN  = 3'd5
    } asram_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } asram_pins_t;

    // Map a sequencer state to the strobe levels and the driver enable.
    function automatic asram_pins_t pins_of(asram_state_e st);
        asram_pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        case (st)
            ST_WSETUP: p.ce_n = 1'b0;
            ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
            ST_WHOLD:  begin p.ce_n = 1'b0; p.drv = 1'b1; end
            ST_RACC:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
`timescale 1ns/1ps
// Down-counter for wait states. A load gives the number of extra cycles
// to wait; expired is high once the count has reached zero.
// Assumes: load_val < MAX_WAIT. With MAX_WAIT <= 1 no counter is built.
module asram_wait_cnt #(
    parameter int MAX_WAIT = 11,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    generate
        if (MAX_WAIT <= 1) begin : g_none
            logic unused_ok;
            // Nothing to count: every wait is a single cycle.
            assign unused_ok = ^{clk, rst_n, load, load_val};
            assign expired   = 1'b1;
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt;
            // Load on request, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)             cnt <= '0;
                else if (load)          cnt <= load_val;
                else if (cnt != '0)     cnt <= cnt - 1'b1;
            end
            assign expired = (cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Access sequencer. It takes one request when idle and steps through the
// write (setup, pulse, hold) or read (access, turnaround) states.
// Assumes: the wait counter's expired flag refers to the current state's
// load.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC = 11,
    parameter int WR_CYC = 9,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             ready,
    output logic             accept,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             sample,
    output asram_pins_t      pins
);
    asram_state_e state, state_nx;

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req_valid;
    assign sample = (state == ST_RACC) && expired;
    assign pins   = pins_of(state);

    // Load the counter on read entry or on the step into the write pulse.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (accept && !req_write) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(RD_CYC - 1);
        end else if (state == ST_WSETUP) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(WR_CYC - 1);
        end
    end

    // Next-state choice.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = req_write ? ST_WSETUP : ST_RACC;
            ST_WSETUP: state_nx = ST_WPULSE;
            ST_WPULSE: if (expired) state_nx = ST_WHOLD;
            ST_WHOLD:  state_nx = ST_IDLE;
            ST_RACC:   if (expired) state_nx = ST_RTURN;
            ST_RTURN:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
// Address and data registers. It latches the address and write word when
// a request is taken, and it captures the bus word when the sequencer
// samples.
// Assumes: mem_dq_in is settled at the sampling edge.
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Hold the address and write word for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // Capture read data and raise a one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) rsp_rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. It derives the read wait from
// the access time and clock period, and it owns the tri-state driver.
// Assumes: the host keeps request fields stable while req_valid is high.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int CLK_PS       = 5000,
    parameter int ACCESS_PS    = 55000,
    parameter int WR_PULSE_CYC = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int RD_CYC   = (ACCESS_PS + CLK_PS - 1) / CLK_PS;
    localparam int MAX_WAIT = (RD_CYC > WR_PULSE_CYC) ? RD_CYC : WR_PULSE_CYC;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

    logic             accept, cnt_load, expired, sample, drv_en;
    logic [CNT_W-1:0] cnt_val;
    logic [DATA_W-1:0] wdata_q;
    asram_pins_t      pins;

    asram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_PULSE_CYC), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .expired(expired), .ready(req_ready), .accept(accept),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .sample(sample), .pins(pins)
    );

    asram_wait_cnt #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .expired(expired)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .sample(sample), .mem_dq_in(mem_dq),
        .mem_addr(mem_addr), .wdata_q(wdata_q), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // Strobes and driver enable come straight from the sequencer state.
    assign mem_ce_n = pins.ce_n;
    assign mem_oe_n = pins.oe_n;
    assign mem_we_n = pins.we_n;
    assign drv_en   = pins.drv;
    assign mem_dq   = drv_en ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for asram_ctrl, attached by bind. It counts pulse
// lengths so that no check depends on a deep $past.
module asram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int RD_CYC = 11,
    parameter int WR_CYC = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              drv_en
);
    int rd_run, wr_run;

    // Count the cycles of the current read and write pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run <= 0;
            wr_run <= 0;
        end else begin
            if (!mem_oe_n)      rd_run <= rd_run + 1;
            else if (req_ready) rd_run <= 0;
            if (!mem_we_n)      wr_run <= wr_run + 1;
            else if (req_ready) wr_run <= 0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !drv_en));
    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    p_ce_leads_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n));
    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wr_run == WR_CYC));
    p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (drv_en && !mem_ce_n));
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> !drv_en);
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    p_read_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (rd_run == RD_CYC));
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && mem_we_n && !req_ready));
    p_no_drive_on_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> mem_oe_n);
    p_oe_we_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WR_CYC(WR_PULSE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .drv_en(drv_en)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: full write/read sweep over a 256-word configuration with a
// timed behavioural memory model.
module asram_ctrl_tb;
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int CLK_PS = 5000;
    localparam int ACC_PS = 55000;
    localparam int WR     = 4;
    localparam int RD     = (ACC_PS + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ce_n, oe_n, we_n;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] dq;

    int n_run = 0, n_fail = 0, overlap_bad = 0;

    always #2.5 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS),
                 .ACCESS_PS(ACC_PS), .WR_PULSE_CYC(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_dq(dq)
    );

    // Behavioural memory: correct data only 54 ns after the read settles.
    logic [DW-1:0] mem [256];
    logic acc_ok = 1'b0;
    int   stamp = 0;
    wire  rd_cond = !ce_n && !oe_n && we_n;
    wire  wr_end  = ce_n | we_n;
    assign dq = rd_cond ? (acc_ok ? mem[mem_addr] : ~mem[mem_addr]) : {DW{1'bz}};

    initial for (int i = 0; i < 256; i++) mem[i] = '0;

    always @(mem_addr or rd_cond) begin
        stamp = stamp + 1;
        acc_ok = 1'b0;
        if (rd_cond) begin
            fork
                begin
                    automatic int my = stamp;
                    #54;
                    if (my == stamp) acc_ok = 1'b1;
                end
            join_none
        end
    end

    always @(posedge wr_end) if (rst_n) mem[mem_addr] = dq;

    // R8 monitor: output enable and write strobe never low together.
    always @(negedge clk) if (rst_n && !oe_n && !we_n) overlap_bad++;

    function automatic logic [7:0] pat_a(int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one request and profile the strobes until idle again.
    task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int ce_c, output int oe_c, output int we_c,
                          output int first_we, output int rsp_n, output int rsp_c,
                          output int turn, output int hold_ok, output int addr_ok,
                          output int done_n, output logic [DW-1:0] rd);
        int n;
        bit prev_we_low;
        ce_c = 0; oe_c = 0; we_c = 0; first_we = 0; rsp_n = 0; rsp_c = 0;
        turn = 0; hold_ok = 0; addr_ok = 1; done_n = 0; rd = '0;
        prev_we_low = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (n = 1; n < 64; n++) begin
            if (req_ready) begin done_n = n; break; end
            if (!ce_n) ce_c++;
            if (!oe_n) begin oe_c++; if (mem_addr != a) addr_ok = 0; end
            if (we_n && prev_we_low && !ce_n) hold_ok = 1;
            prev_we_low = !we_n;
            if (!we_n) begin we_c++; if (first_we == 0) first_we = n; end
            if (rsp_valid) begin rsp_c++; rsp_n = n; rd = rsp_rdata; end
            if (ce_n && oe_n && we_n) turn = 1;
            @(negedge clk);
        end
    endtask

    initial begin
        int ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn;
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && we_n && !rsp_valid, "R1 in reset", {ce_n, oe_n, we_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && ce_n && oe_n && we_n, "R1 idle", {req_ready, ce_n, oe_n, we_n}, 15);

        // Write sweep over every address.
        for (int a = 0; a < 256; a++) begin
            run_op(1'b1, AW'(a), pat_a(a), ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(we_c == WR, "R3 pulse length", we_c, WR);
            chk(fw == 2 && oe_c == 0, "R3 setup then strobe, oe high", fw, 2);
            chk(ho == 1 && ce_c == WR + 2, "R4 hold cycle with ce low", ce_c, WR + 2);
            chk(dn == WR + 3, "R4 idle after write", dn, WR + 3);
        end

        // Read sweep: data, latency and turnaround.
        for (int a = 0; a < 256; a++) begin
            run_op(1'b0, AW'(a), '0, ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(oe_c == RD && ce_c == RD && we_c == 0, "R5 read window", oe_c, RD);
            chk(ao == 1, "R5 address stable", ao, 1);
            chk(rc == 1 && rn == RD + 1, "R6 response pulse timing", rn, RD + 1);
            chk(tn == 1 && dn == RD + 2, "R7 turnaround cycle", dn, RD + 2);
            chk(rd == pat_a(a), "R9 read back", rd, pat_a(a));
        end

        // Interleaved read/write/read on the low addresses.
        for (int a = 0; a < 16; a++) begin
            run_op(1'b0, AW'(a), '0, ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(tn == 1, "R7 turnaround before write", tn, 1);
            run_op(1'b1, AW'(a), ~pat_a(a), ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            run_op(1'b0, AW'(a), '0, ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(rd == ~pat_a(a), "R9 overwrite", rd, ~pat_a(a));
        end

        // R2: a request held during a busy write starts no access.
        begin
            int falls = 0, rdy_hi = 0;
            bit prev_ce = 1'b1;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd40; req_wdata = 8'hA5;
            @(negedge clk);
            req_addr = 8'd41; req_wdata = 8'h5A;
            for (int n = 1; n <= WR + 2; n++) begin
                if (req_ready) rdy_hi++;
                if (prev_ce && !ce_n) falls++;
                prev_ce = ce_n;
                if (n == WR + 2) req_valid = 1'b0;
                else @(negedge clk);
            end
            chk(rdy_hi == 0, "R2 ready low while busy", rdy_hi, 0);
            chk(falls == 1, "R2 single access", falls, 1);
            run_op(1'b0, 8'd41, '0, ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(rd == pat_a(41), "R2 held request ignored", rd, pat_a(41));
            run_op(1'b0, 8'd40, '0, ce_c, oe_c, we_c, fw, rn, rc, tn, ho, ao, dn, rd);
            chk(rd == 8'hA5, "R2 taken request written", rd, 8'hA5);
        end

        chk(overlap_bad == 0, "R8 oe and we never low together", overlap_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule